// File: doc/BRIEF.md
# Narrow-to-Wide Floating-Point Converter

This block turns a short floating-point code (an 8-bit format with a 4-bit exponent and 3-bit fraction, a 5/2 split, or a 16-bit format with an 8-bit exponent) into an IEEE-style wider word, 32-bit single precision by default. Every value in the narrow format can be represented exactly in the wide one, so there is no rounding. The fraction is padded with zeros on the right, and the exponent moves to the new bias. Source subnormals become wide normals through a leading-one search and a barrel shift in one cycle. When the two formats have the same exponent width, subnormals stay subnormal.

The converter accepts one word per clock when its valid strobe is high. It presents the result one clock later on a registered output with its own valid strobe. The source's special-value convention is chosen by a parameter. It can be full IEEE (infinity and NaN), NaN-only (only all-ones exponent with all-ones fraction is NaN, and there is no infinity), or none.

Top module: `fpw_widen`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock. When `in_valid` is high, the converted word appears on `out_word` one clock later.
- R2: When `in_valid` is low, `out_word` keeps its previous value, whatever is on `in_word`.
- R3: A synchronous active-high `rst` clears `out_valid` and `out_word` to zero at the next clock.
- R4: For a normal finite source, the output sign is the source sign (top bit). The output exponent is the source exponent plus (wide bias − narrow bias), where bias = 2^(exponent width − 1) − 1. The output fraction is the source fraction shifted left by the difference in fraction widths. Example: 8-bit 0x7E gives 0x43E00000 (448.0); in NaN-only mode exponent 1111 with a fraction other than 111 is finite.
- R5: A source with zero exponent and zero fraction gives zero exponent and zero fraction, with the sign kept: 0x00 gives 0x00000000 and 0x80 gives 0x80000000.
- R6: When the exponent widths differ, a subnormal source becomes a wide normal of identical real value. Example: 8-bit 0x01 (2^-9) gives 0x3B000000.
- R7: When the exponent widths are equal, a subnormal source stays subnormal: the exponent is zero and the fraction is padded. Example: 16-bit 0x0001 gives 0x00010000.
- R8: A source NaN gives the canonical quiet NaN with the source sign: exponent all ones, fraction MSB set, other fraction bits zero. So 8-bit 0xFF gives 0xFFC00000, and 16-bit 0x7F81 gives 0x7FC00000.
- R9: A source infinity (IEEE mode: exponent all ones and fraction zero) gives wide infinity with the sign kept. Example: 16-bit 0xFF80 gives 0xFF800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source word strobe |
| in_word | input | 1+SRC_EXP_W+SRC_MAN_W | Narrow floating-point code {sign, exponent, fraction} |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_word | output | 1+DST_EXP_W+DST_MAN_W | Wide floating-point result {sign, exponent, fraction} |

## Verification
Four properties hold on every cycle: the one-clock valid delay, the holding of the output word while idle, sign propagation, and zero mapping to zero magnitude. The reset-clear property is checked at each clock edge that follows a reset cycle. The numeric correctness of normals, both subnormal paths, NaN and infinity can only be shown by the bench. It sweeps every 16-bit code through an equal-exponent-width instance and every 8-bit code through the default instance. Each result is compared against a wide encoding built from the real value of the source.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  // Source special-value convention
  typedef enum logic [1:0] {
    SPC_IEEE     = 2'd0,  // all-ones exponent: zero fraction = inf, else NaN
    SPC_NAN_ONLY = 2'd1,  // all-ones exponent and fraction = NaN, no inf
    SPC_NONE     = 2'd2   // every code is finite
  } spc_mode_e;

  typedef struct packed {
    logic is_zero;
    logic is_sub;
    logic is_inf;
    logic is_nan;
  } cls_t;
endpackage

// File: rtl/fpw_classify.sv
module fpw_classify
  import fpw_pkg::*;
#(
  parameter int        EW  = 4,
  parameter int        MW  = 3,
  parameter spc_mode_e SPC = SPC_NAN_ONLY
) (
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] man_i,
  output cls_t          cls_o
);
  logic exp_max, exp_zero, man_zero, man_full;

  always_comb begin
    exp_max  = &exp_i;
    exp_zero = ~|exp_i;
    man_zero = ~|man_i;
    man_full = &man_i;
    cls_o.is_zero = exp_zero & man_zero;
    cls_o.is_sub  = exp_zero & ~man_zero;
    case (SPC)
      SPC_IEEE: begin
        cls_o.is_inf = exp_max & man_zero;
        cls_o.is_nan = exp_max & ~man_zero;
      end
      SPC_NAN_ONLY: begin
        cls_o.is_inf = 1'b0;
        cls_o.is_nan = exp_max & man_full;
      end
      default: begin
        cls_o.is_inf = 1'b0;
        cls_o.is_nan = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fpw_lead_one.sv
// Shift distance that moves the highest set bit just past the MSB.
module fpw_lead_one #(
  parameter int W  = 3,
  parameter int PW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] shl_o
);
  always_comb begin
    shl_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) shl_o = PW'(W - i);
    end
  end
endmodule

// File: rtl/fpw_subnorm.sv
module fpw_subnorm #(
  parameter int SEW = 4,
  parameter int SMW = 3,
  parameter int DEW = 8,
  parameter int DMW = 23
) (
  input  logic [SMW-1:0] man_i,
  output logic [DEW-1:0] exp_o,
  output logic [DMW-1:0] man_o
);
  localparam int BS  = (1 << (SEW - 1)) - 1;
  localparam int BD  = (1 << (DEW - 1)) - 1;
  localparam int PAD = DMW - SMW;
  localparam int PW  = $clog2(SMW + 1);

  generate
    if (SEW == DEW) begin : g_same
      // Same bias: value keeps its subnormal encoding
      assign exp_o = '0;
      assign man_o = DMW'(man_i) << PAD;
    end else begin : g_norm
      logic [PW-1:0]  shl;
      logic [SMW-1:0] man_sh;
      fpw_lead_one #(.W(SMW), .PW(PW)) u_lz (.vec_i(man_i), .shl_o(shl));
      assign man_sh = man_i << shl;  // hidden one drops off the top
      assign exp_o  = DEW'(BD - BS + 1) - DEW'(shl);
      assign man_o  = DMW'(man_sh) << PAD;
    end
  endgenerate
endmodule

// File: rtl/fpw_widen.sv
module fpw_widen
  import fpw_pkg::*;
#(
  parameter int        SRC_EXP_W = 4,
  parameter int        SRC_MAN_W = 3,
  parameter spc_mode_e SRC_SPC   = SPC_NAN_ONLY,
  parameter int        DST_EXP_W = 8,
  parameter int        DST_MAN_W = 23,
  localparam int       SW        = 1 + SRC_EXP_W + SRC_MAN_W,
  localparam int       DW        = 1 + DST_EXP_W + DST_MAN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [SW-1:0] in_word,
  output logic          out_valid,
  output logic [DW-1:0] out_word
);
  localparam int BS  = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int BD  = (1 << (DST_EXP_W - 1)) - 1;
  localparam int PAD = DST_MAN_W - SRC_MAN_W;

  logic                 s_sign;
  logic [SRC_EXP_W-1:0] s_exp;
  logic [SRC_MAN_W-1:0] s_man;
  cls_t                 cls;
  logic [DST_EXP_W-1:0] sub_exp, nrm_exp;
  logic [DST_MAN_W-1:0] sub_man, nrm_man;
  logic [DW-1:0]        res;

  assign {s_sign, s_exp, s_man} = in_word;

  fpw_classify #(.EW(SRC_EXP_W), .MW(SRC_MAN_W), .SPC(SRC_SPC)) u_cls (
    .exp_i(s_exp), .man_i(s_man), .cls_o(cls)
  );

  fpw_subnorm #(.SEW(SRC_EXP_W), .SMW(SRC_MAN_W), .DEW(DST_EXP_W), .DMW(DST_MAN_W)) u_sub (
    .man_i(s_man), .exp_o(sub_exp), .man_o(sub_man)
  );

  assign nrm_exp = DST_EXP_W'(s_exp) + DST_EXP_W'(BD - BS);
  assign nrm_man = DST_MAN_W'(s_man) << PAD;

  always_comb begin
    if (cls.is_nan)
      res = {s_sign, {DST_EXP_W{1'b1}}, 1'b1, {(DST_MAN_W-1){1'b0}}};
    else if (cls.is_inf)
      res = {s_sign, {DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};
    else if (cls.is_zero)
      res = {s_sign, {(DW-1){1'b0}}};
    else if (cls.is_sub)
      res = {s_sign, sub_exp, sub_man};
    else
      res = {s_sign, nrm_exp, nrm_man};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= res;
    end
  end
endmodule

// File: rtl/fpw_widen_chk.sv
module fpw_widen_chk #(
  parameter int SW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [SW-1:0] in_word,
  input logic          out_valid,
  input logic [DW-1:0] out_word
);
  p_valid_delay_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(out_word));

  p_reset_clear_r3: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_word == '0));

  p_sign_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> (out_word[DW-1] == $past(in_word[SW-1])));

  p_zero_map_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(in_word[SW-2:0]) == '0)
      |-> (out_word[DW-2:0] == '0));
endmodule

bind fpw_widen fpw_widen_chk #(.SW(SW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .out_word(out_word)
);

// File: tb/sim_fpw_widen.sv
`timescale 1ns/1ps
module sim_fpw_widen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vin = 1'b0;
  logic [7:0]  a_in = '0;
  logic [15:0] b_in = '0;
  logic        a_vo, b_vo;
  logic [31:0] a_out, b_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit armed = 0;
  logic        e_v = 1'b0;
  logic [31:0] e_a = '0, e_b = '0;
  string       t_a = "R3", t_b = "R3", t_v = "R3";

  always #4 clk = ~clk;  // 125 MHz

  fpw_widen u0 (
    .clk(clk), .rst(rst), .in_valid(vin), .in_word(a_in),
    .out_valid(a_vo), .out_word(a_out)
  );

  fpw_widen #(.SRC_EXP_W(8), .SRC_MAN_W(7), .SRC_SPC(fpw_pkg::SPC_IEEE)) u1 (
    .clk(clk), .rst(rst), .in_valid(vin), .in_word(b_in),
    .out_valid(b_vo), .out_word(b_out)
  );

  function automatic real p2(int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  // Single-precision encoding of an exactly representable magnitude
  function automatic logic [31:0] enc32(logic s, real mag);
    real v = mag;
    int  e = 0;
    if (mag < p2(-126)) return {s, 8'd0, 23'(longint'(mag * p2(149)))};
    while (v >= 2.0) begin v = v / 2.0; e++; end
    while (v < 1.0)  begin v = v * 2.0; e--; end
    return {s, 8'(e + 127), 23'(longint'((v - 1.0) * p2(23)))};
  endfunction

  function automatic real mag_of(int e, int m, int ew, int mw);
    int bias = (1 << (ew - 1)) - 1;
    if (e == 0) return real'(m) * p2(1 - bias - mw);
    return real'((1 << mw) + m) * p2(e - bias - mw);
  endfunction

  task automatic ref_a(input logic [7:0] w, output logic [31:0] r, output string t);
    int e = int'(w[6:3]);
    int m = int'(w[2:0]);
    if (e == 15 && m == 7)   begin r = {w[7], 8'hFF, 1'b1, 22'd0}; t = "R8"; end
    else if (e == 0 && m == 0) begin r = {w[7], 31'd0}; t = "R5"; end
    else begin
      r = enc32(w[7], mag_of(e, m, 4, 3));
      t = (e == 0) ? "R6" : "R4";
    end
  endtask

  task automatic ref_b(input logic [15:0] w, output logic [31:0] r, output string t);
    int e = int'(w[14:7]);
    int m = int'(w[6:0]);
    if (e == 255 && m != 0)    begin r = {w[15], 8'hFF, 1'b1, 22'd0}; t = "R8"; end
    else if (e == 255)         begin r = {w[15], 8'hFF, 23'd0}; t = "R9"; end
    else if (e == 0 && m == 0) begin r = {w[15], 31'd0}; t = "R5"; end
    else begin
      r = enc32(w[15], mag_of(e, m, 8, 7));
      t = (e == 0) ? "R7" : "R4";
    end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input logic [15:0] b, input logic v, input logic r);
    logic [31:0] ra, rb;
    string sa, sb;
    @(negedge clk);
    if (armed) begin
      chk(t_v, "u0 valid", {31'd0, a_vo}, {31'd0, e_v});
      chk(t_v, "u1 valid", {31'd0, b_vo}, {31'd0, e_v});
      chk(t_a, "u0 word", a_out, e_a);
      chk(t_b, "u1 word", b_out, e_b);
    end
    armed = 1;
    rst = r; vin = v; a_in = a; b_in = b;
    if (r) begin
      e_v = 1'b0; e_a = '0; e_b = '0; t_a = "R3"; t_b = "R3"; t_v = "R3";
    end else begin
      e_v = v; t_v = "R1";
      if (v) begin
        ref_a(a, ra, sa); ref_b(b, rb, sb);
        e_a = ra; e_b = rb; t_a = sa; t_b = sb;
      end else begin
        t_a = "R2"; t_b = "R2";
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc(8'h00, 16'h0000, 1'b1, 1'b1);
    cyc(8'h00, 16'h0000, 1'b0, 1'b0);  // reset state observed next
    // Corner codes first
    cyc(8'h7E, 16'h0001, 1'b1, 1'b0);
    cyc(8'h01, 16'hFF80, 1'b1, 1'b0);
    cyc(8'hFF, 16'h7F81, 1'b1, 1'b0);
    cyc(8'h80, 16'h8000, 1'b1, 1'b0);
    // Exhaustive sweep: every 16-bit code on u1, every 8-bit code on u0
    for (int i = 0; i < 65536; i++) cyc(8'(i), 16'(i), 1'b1, 1'b0);
    // Idle cycles with changing data must not disturb the outputs (R2)
    for (int k = 0; k < 60; k++) cyc(8'(k * 37 + 5), 16'(k * 4099 + 11), (k % 3) == 0, 1'b0);
    // Reset in mid-traffic (R3)
    cyc(8'h55, 16'h3F80, 1'b1, 1'b1);
    cyc(8'h3C, 16'h4000, 1'b1, 1'b0);
    cyc(8'h00, 16'h0000, 1'b0, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(80000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule